// File: doc/BRIEF.md
# Programmable Root Counter Timer

This block is one 16-bit timer channel behind a small register port. Software writes a count, a control word and a compare value, and the channel then advances once per tick from a clock source picked by the control word. It can fold back to zero when the count reaches the compare value, or it can run on to all-ones and wrap. Reaching the compare value and reaching all-ones are both events. Each event can raise a one-cycle interrupt pulse, either only the first time after the control word is written or every time. Sticky status bits record the events, and a read of the control word clears them.

The parameter `FLAV` picks one of three channel flavours. Flavour 0 can count an external dot-rate tick. Flavour 1 can count an external line-rate tick. Flavour 2 can count the system enable divided by eight, and it has a halt bit. The interrupt pulse leaves the block together with a flavour-specific bit code, so that logic outside the block can OR it into a shared status register.

Top module: `prog_timer`

## Requirements
- R1: A write with `reg_sel`=0 loads the count with the low 16 bits of `reg_wdata` and discards the upper bits. A read with `reg_sel`=0 returns the count. `reg_sel`=2 selects the compare value and `reg_sel`=1 selects the control word.
- R2: The count advances by one per tick. Ticks come from `sys_ce` unless a source bit picks another source. On flavour 0, control bit 8 selects `dot_tick`. On flavour 1, control bit 8 selects `line_tick`. On flavour 2, control bit 9 selects one tick per 8 `sys_ce` pulses, and the divider restarts on a control write. Unselected sources have no effect.
- R3: On flavour 2, control bit 0 set halts counting.
- R4: With control bit 3 set, a tick that would make the count equal the compare value sets the count to 0 instead.
- R5: With control bit 3 clear, the count passes the compare value, reaches 0xFFFF and wraps to 0 on the next tick.
- R6: Reaching the compare value sets status bit 11, and reaching 0xFFFF sets status bit 12. Either event sets bit 10.
- R7: A control-word read returns the value it had before the read, then clears bits 11 and 12. Bit 10 is kept.
- R8: Bit 4 enables an interrupt on the compare event and bit 5 enables one on the 0xFFFF event. `irq_pulse` is high for one cycle, in the cycle after the tick. `irq_code` is 0x10, 0x20 or 0x40 for flavours 0, 1 and 2 while the pulse is high, and 0 otherwise.
- R9: With bit 6 clear, only the first enabled event after a control write raises a pulse. With bit 6 set, every enabled event raises one.
- R10: A control write stores bits 9:0, sets the count to 0, clears bits 10 to 12 and re-arms the interrupt.
- R11: A compare-value write leaves the count unchanged. A tick that arrives in the same cycle as any register write is dropped.
- R12: Bits 15:13 of the control word read as zero.
- R13: After reset, the count, the control word and the compare value read 0, and `irq_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_ce | input | 1 | System clock enable, the default tick |
| dot_tick | input | 1 | External dot-rate tick |
| line_tick | input | 1 | External line-rate tick |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a control-word read clears flags |
| reg_sel | input | 2 | Register select: 0 count, 1 control, 2 compare |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_code | output | 8 | Channel status bit while pulsing, else 0 |

## Verification
The bench sweeps the compare value from 1 to 6 in fold-back mode and checks each count against the tick number modulo the compare value. A design that folds back one tick late or one tick early fails this sweep. It steps the divide-by-eight source one tick at a time and restarts the divider partway through a period, which catches a divider that is never re-phased. It reaches 0xFFFF from just below and then takes one more tick, which exposes an overflow event tied to the wrap instead of the all-ones value. It counts interrupt pulses in one-shot and repeat modes and after a re-arm, so a latch that never re-arms, or that never blocks later events, shows up as a wrong pulse total. It reads the control word twice in a row, which catches flags that are not cleared, that are cleared before the read is returned, or that take bit 10 down with them.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int REG_W = 16;
    localparam int BUS_W = 32;

    localparam int FLAV_DOT  = 0;
    localparam int FLAV_LINE = 1;
    localparam int FLAV_DIV  = 2;

    localparam int B_HALT    = 0;
    localparam int B_RST_TGT = 3;
    localparam int B_IRQ_TGT = 4;
    localparam int B_IRQ_OVF = 5;
    localparam int B_IRQ_RPT = 6;
    localparam int B_ALT_SRC = 8;
    localparam int B_DIV_SRC = 9;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_CTRL   = 2'd1,
        SEL_TARGET = 2'd2,
        SEL_NONE   = 2'd3
    } tmr_sel_e;

    typedef struct packed {
        logic tgt;
        logic ovf;
    } tmr_evt_t;

    typedef struct packed {
        logic [2:0] zero;
        logic       ovf_hit;
        logic       tgt_hit;
        logic       evt_any;
        logic [9:0] ctl;
    } tmr_ctrl_view_t;

    function automatic logic [7:0] irq_mask(input int flav);
        return 8'h10 << flav;
    endfunction

endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel
    import timer_pkg::*;
#(
    parameter int FLAV = 0,
    parameter int DIV  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       sys_ce,
    input  logic       dot_tick,
    input  logic       line_tick,
    input  logic [9:0] ctl,
    output logic       tick
);

    if (FLAV == FLAV_DOT) begin : g_dot
        logic unused_in;
        assign unused_in = ^{clk, rst, restart, line_tick, ctl};
        assign tick = ctl[B_ALT_SRC] ? dot_tick : sys_ce;
    end else if (FLAV == FLAV_LINE) begin : g_line
        logic unused_in;
        assign unused_in = ^{clk, rst, restart, dot_tick, ctl};
        assign tick = ctl[B_ALT_SRC] ? line_tick : sys_ce;
    end else begin : g_div
        localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
        localparam logic [PW-1:0] LAST = PW'(DIV - 1);
        logic [PW-1:0] pre;
        logic          div_tick;
        logic          unused_in;
        assign unused_in = ^{dot_tick, line_tick, ctl};

        always_ff @(posedge clk) begin
            if (rst || restart) begin
                pre <= '0;
            end else if (sys_ce) begin
                pre <= (pre == LAST) ? '0 : pre + 1'b1;
            end
        end

        assign div_tick = sys_ce && (pre == LAST);
        assign tick = ctl[B_HALT] ? 1'b0 : (ctl[B_DIV_SRC] ? div_tick : sys_ce);
    end

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] tgt,
    input  logic         rst_on_tgt,
    output logic [W-1:0] cnt,
    output tmr_evt_t     evt
);

    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;
    assign evt.tgt = tick && (cnt_inc == tgt);
    assign evt.ovf = tick && (cnt_inc == '1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick) begin
            cnt <= (evt.tgt && rst_on_tgt) ? '0 : cnt_inc;
        end
    end

endmodule

// File: rtl/tmr_irq_gen.sv
module tmr_irq_gen
    import timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rearm,
    input  tmr_evt_t evt,
    input  logic     en_tgt,
    input  logic     en_ovf,
    input  logic     repeat_en,
    output logic     irq_pulse
);

    logic spent;
    logic fire;

    assign fire = ((evt.tgt && en_tgt) || (evt.ovf && en_ovf)) && (repeat_en || !spent);

    always_ff @(posedge clk) begin
        if (rst) begin
            spent     <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= fire;
            if (rearm) begin
                spent <= 1'b0;
            end else if (fire) begin
                spent <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/prog_timer.sv
module prog_timer
    import timer_pkg::*;
#(
    parameter int FLAV = 0,
    parameter int W    = 16,
    parameter int DIV  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_ce,
    input  logic             dot_tick,
    input  logic             line_tick,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_sel,
    input  logic [BUS_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_pulse,
    output logic [7:0]       irq_code
);

    localparam logic [7:0] IRQ_BIT = irq_mask(FLAV);

    tmr_sel_e       sel;
    logic           wr_count, wr_ctrl, wr_target, any_wr, rd_ctrl;
    logic [9:0]     ctl;
    logic           evt_any, tgt_hit, ovf_hit;
    logic [W-1:0]   target;
    logic [W-1:0]   cnt;
    logic           raw_tick, tick_g;
    tmr_evt_t       evt;
    tmr_ctrl_view_t ctrl_view;
    logic           unused_hi;

    assign unused_hi = ^reg_wdata[BUS_W-1:REG_W];

    assign sel       = tmr_sel_e'(reg_sel);
    assign wr_count  = reg_wr && (sel == SEL_COUNT);
    assign wr_ctrl   = reg_wr && (sel == SEL_CTRL);
    assign wr_target = reg_wr && (sel == SEL_TARGET);
    assign any_wr    = wr_count || wr_ctrl || wr_target;
    assign rd_ctrl   = reg_rd && (sel == SEL_CTRL);

    tmr_tick_sel #(.FLAV(FLAV), .DIV(DIV)) tick_i (
        .clk       (clk),
        .rst       (rst),
        .restart   (wr_ctrl),
        .sys_ce    (sys_ce),
        .dot_tick  (dot_tick),
        .line_tick (line_tick),
        .ctl       (ctl),
        .tick      (raw_tick)
    );

    assign tick_g = raw_tick && !any_wr;

    tmr_count_core #(.W(W)) core_i (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_g),
        .restart    (wr_ctrl),
        .load       (wr_count),
        .load_val   (reg_wdata[W-1:0]),
        .tgt        (target),
        .rst_on_tgt (ctl[B_RST_TGT]),
        .cnt        (cnt),
        .evt        (evt)
    );

    tmr_irq_gen irq_i (
        .clk       (clk),
        .rst       (rst),
        .rearm     (wr_ctrl),
        .evt       (evt),
        .en_tgt    (ctl[B_IRQ_TGT]),
        .en_ovf    (ctl[B_IRQ_OVF]),
        .repeat_en (ctl[B_IRQ_RPT]),
        .irq_pulse (irq_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            target  <= '0;
            evt_any <= 1'b0;
            tgt_hit <= 1'b0;
            ovf_hit <= 1'b0;
        end else begin
            if (wr_target) begin
                target <= reg_wdata[W-1:0];
            end
            if (wr_ctrl) begin
                ctl     <= reg_wdata[9:0];
                evt_any <= 1'b0;
                tgt_hit <= 1'b0;
                ovf_hit <= 1'b0;
            end else begin
                evt_any <= evt_any || evt.tgt || evt.ovf;
                tgt_hit <= evt.tgt || (tgt_hit && !rd_ctrl);
                ovf_hit <= evt.ovf || (ovf_hit && !rd_ctrl);
            end
        end
    end

    always_comb begin
        ctrl_view.zero    = 3'b000;
        ctrl_view.ovf_hit = ovf_hit;
        ctrl_view.tgt_hit = tgt_hit;
        ctrl_view.evt_any = evt_any;
        ctrl_view.ctl     = ctl;
    end

    always_comb begin
        case (sel)
            SEL_COUNT:  reg_rdata = REG_W'(cnt);
            SEL_CTRL:   reg_rdata = ctrl_view;
            SEL_TARGET: reg_rdata = REG_W'(target);
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_code = irq_pulse ? IRQ_BIT : 8'h00;

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         reg_wr,
    input logic         reg_rd,
    input logic [1:0]   reg_sel,
    input logic [15:0]  reg_rdata,
    input logic         irq_pulse,
    input logic [W-1:0] cnt,
    input logic [9:0]   ctl,
    input logic         tgt_hit,
    input logic         ovf_hit,
    input logic         evt_any,
    input logic [1:0]   evt
);

    logic unused_chk;
    assign unused_chk = ^{reg_rdata[12:0], ctl[9:7], ctl[5:0]};

    assert_mode_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd1) |=> (cnt == '0 && !tgt_hit && !ovf_hit && !evt_any));

    assert_target_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_sel == 2'd2) |=> (cnt == $past(cnt)));

    assert_rdclr_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_sel == 2'd1 && evt == 2'b00) |=> (!tgt_hit && !ovf_hit));

    assert_top_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (reg_sel == 2'd1) |-> (reg_rdata[15:13] == 3'b000));

    assert_oneshot_R9: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse && !ctl[6]) |=> !irq_pulse);

    assert_event_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (evt != 2'b00) |=> evt_any);

endmodule

bind prog_timer tmr_checker #(.W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_sel   (reg_sel),
    .reg_rdata (reg_rdata),
    .irq_pulse (irq_pulse),
    .cnt       (cnt),
    .ctl       (ctl),
    .tgt_hit   (tgt_hit),
    .ovf_hit   (ovf_hit),
    .evt_any   (evt_any),
    .evt       (evt)
);

// File: tb/prog_timer_tb_top.sv
module prog_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_ce = 1'b0, dot_tick = 1'b0, line_tick = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [15:0] rd0, rd1, rd2;
    logic        irq0, irq1, irq2;
    logic [7:0]  code0, code1, code2;

    int n_chk = 0, n_fail = 0;
    int pc0 = 0, pc1 = 0, pc2 = 0, code_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prog_timer #(.FLAV(0)) dut_i (
        .clk(clk), .rst(rst), .sys_ce(sys_ce), .dot_tick(dot_tick), .line_tick(line_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rd0), .irq_pulse(irq0), .irq_code(code0));
    prog_timer #(.FLAV(1)) dut1_i (
        .clk(clk), .rst(rst), .sys_ce(sys_ce), .dot_tick(dot_tick), .line_tick(line_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rd1), .irq_pulse(irq1), .irq_code(code1));
    prog_timer #(.FLAV(2)) dut2_i (
        .clk(clk), .rst(rst), .sys_ce(sys_ce), .dot_tick(dot_tick), .line_tick(line_tick),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(rd2), .irq_pulse(irq2), .irq_code(code2));

    // pulse and code monitor (R8)
    always @(negedge clk) begin
        if (!rst) begin
            if (irq0) pc0++;
            if (irq1) pc1++;
            if (irq2) pc2++;
            if (code0 !== (irq0 ? 8'h10 : 8'h00)) code_err++;
            if (code1 !== (irq1 ? 8'h20 : 8'h00)) code_err++;
            if (code2 !== (irq2 ? 8'h40 : 8'h00)) code_err++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        reg_sel = sel;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] a, output logic [15:0] b,
                      output logic [15:0] c);
        reg_sel = sel;
        reg_rd = 1'b1;
        #1;
        a = rd0;
        b = rd1;
        c = rd2;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    // src: 0 sys_ce, 1 dot_tick, 2 line_tick
    task automatic run(input int n, input int src);
        for (int i = 0; i < n; i++) begin
            sys_ce = (src == 0);
            dot_tick = (src == 1);
            line_tick = (src == 2);
            @(negedge clk);
        end
        sys_ce = 1'b0;
        dot_tick = 1'b0;
        line_tick = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] a, b, c;
        int base0, base1, base2;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        rd(2'd0, a, b, c); chk("R13 count", a, 0);
        rd(2'd1, a, b, c); chk("R13 ctrl", a, 0);
        rd(2'd2, a, b, c); chk("R13 target", a, 0);
        chk("R13 irq", irq0, 0);

        // R1 truncation
        wr(2'd0, 32'h0001_2345);
        rd(2'd0, a, b, c);
        chk("R1 f0", a, 16'h2345); chk("R1 f1", b, 16'h2345); chk("R1 f2", c, 16'h2345);

        // R2 system enable, other sources ignored
        wr(2'd1, 0);
        for (int n = 1; n <= 17; n += 8) begin
            wr(2'd0, 0);
            run(n, 0);
            rd(2'd0, a, b, c); chk("R2 sys count", a, n);
            run(3, 1); run(3, 2);
            rd(2'd0, a, b, c); chk("R2 other ignored", a, n);
        end

        // R2 alternate sources on bit 8
        wr(2'd1, 32'h100);
        run(4, 1);
        rd(2'd0, a, b, c); chk("R2 dot f0", a, 4); chk("R2 dot f1", b, 0); chk("R2 dot f2", c, 0);
        run(3, 2);
        rd(2'd0, a, b, c); chk("R2 line f0", a, 4); chk("R2 line f1", b, 3); chk("R2 line f2", c, 0);
        run(5, 0);
        rd(2'd0, a, b, c); chk("R2 sys f0", a, 4); chk("R2 sys f1", b, 3); chk("R2 sys f2", c, 5);

        // R2 divide-by-eight sweep on flavour 2
        wr(2'd1, 32'h200);
        for (int k = 1; k <= 20; k++) begin
            run(1, 0);
            rd(2'd0, a, b, c);
            chk("R2 div f2", c, k / 8);
            chk("R2 div f0", a, k);
        end
        run(5, 0);
        wr(2'd1, 32'h200);
        run(3, 0);
        rd(2'd0, a, b, c); chk("R2 div restart", c, 0);
        run(5, 0);
        rd(2'd0, a, b, c); chk("R2 div restart period", c, 1);

        // R3 halt
        wr(2'd1, 32'h001);
        run(6, 0);
        rd(2'd0, a, b, c); chk("R3 halt f2", c, 0); chk("R3 no halt f0", a, 6);
        wr(2'd1, 32'h201);
        run(9, 0);
        rd(2'd0, a, b, c); chk("R3 halt div f2", c, 0);

        // R4 fold-back sweep
        for (int t = 1; t <= 6; t++) begin
            wr(2'd1, 32'h008);
            wr(2'd2, t);
            for (int k = 1; k <= 2 * t + 1; k++) begin
                run(1, 0);
                rd(2'd0, a, b, c);
                chk("R4 fold", a, k % t);
            end
        end

        // R5 pass target, R6 flag without fold-back
        wr(2'd1, 0);
        wr(2'd2, 3);
        run(5, 0);
        rd(2'd0, a, b, c); chk("R5 passes target", a, 5);
        rd(2'd1, a, b, c); chk("R6 tgt flag", a, 16'h0C00);

        // R6 / R7 target event with fold-back
        wr(2'd1, 32'h008);
        wr(2'd2, 4);
        run(4, 0);
        rd(2'd1, a, b, c); chk("R7 pre-clear value", a, 16'h0C08);
        rd(2'd1, a, b, c); chk("R7 cleared keeps bit10", a, 16'h0408);
        rd(2'd0, a, b, c); chk("R4 folded", a, 0);

        // R5 / R6 overflow and wrap
        wr(2'd1, 0);
        wr(2'd0, 32'hFFFE);
        run(1, 0);
        rd(2'd1, a, b, c); chk("R6 ovf flag", a, 16'h1400);
        rd(2'd1, a, b, c); chk("R7 ovf cleared", a, 16'h0400);
        rd(2'd0, a, b, c); chk("R5 at all-ones", a, 16'hFFFF);
        run(1, 0);
        rd(2'd0, a, b, c); chk("R5 wrap", a, 0);
        rd(2'd1, a, b, c); chk("R5 wrap no event", a, 16'h0400);
        wr(2'd1, 0);
        rd(2'd1, a, b, c); chk("R10 flags cleared", a, 0);

        // R8 / R9 one-shot on target
        wr(2'd1, 32'h018);
        wr(2'd2, 4);
        #1; base0 = pc0;
        run(3, 0); chk("R8 no early pulse", irq0, 0);
        run(1, 0); chk("R8 pulse", irq0, 1); chk("R8 code", code0, 8'h10);
        run(1, 0); chk("R8 single cycle", irq0, 0);
        run(15, 0);
        #1; chk("R9 one-shot total", pc0 - base0, 1);

        // R9 repeat
        wr(2'd1, 32'h058);
        #1; base0 = pc0; base1 = pc1; base2 = pc2;
        run(20, 0);
        #1;
        chk("R9 repeat f0", pc0 - base0, 5);
        chk("R9 repeat f1", pc1 - base1, 5);
        chk("R9 repeat f2", pc2 - base2, 5);

        // R10 re-arm
        wr(2'd1, 32'h018);
        #1; base0 = pc0;
        run(8, 0);
        #1; chk("R10 rearm", pc0 - base0, 1);

        // R8 overflow interrupt
        wr(2'd1, 32'h020);
        wr(2'd0, 32'hFFFC);
        #1; base0 = pc0;
        run(2, 0); chk("R8 ovf not yet", irq0, 0);
        run(1, 0); chk("R8 ovf pulse", irq0, 1);
        run(12, 0);
        #1; chk("R8 ovf only", pc0 - base0, 1);
        chk("R8 code monitor", code_err, 0);

        // R11 target write keeps count; coincident tick dropped
        wr(2'd1, 0);
        run(7, 0);
        wr(2'd2, 100);
        rd(2'd0, a, b, c); chk("R11 count kept", a, 7);
        rd(2'd2, a, b, c); chk("R1 target readback", a, 100);
        sys_ce = 1'b1;
        wr(2'd2, 50);
        sys_ce = 1'b0;
        rd(2'd0, a, b, c); chk("R11 tick dropped", a, 7);

        // R12 high bits zero, stored bits
        wr(2'd1, 32'hFFFF);
        rd(2'd1, a, b, c);
        chk("R12 f0", a, 16'h03FF); chk("R12 f1", b, 16'h03FF); chk("R12 f2", c, 16'h03FF);
        rd(2'd0, a, b, c); chk("R10 count zero", a, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule